// File: doc/BRIEF.md
# Linked-descriptor transmit DMA engine

This block is the transmit half of a descriptor-driven Ethernet DMA. Software places descriptors in memory, loads the address of the first one into a pointer register and sets an enable bit. Each descriptor is three consecutive 32-bit words. The engine reads them over a single-outstanding memory port and streams the packet bytes out on a byte-wide valid/ready interface. It then hands the descriptor back to software by setting its empty flag, and follows the next pointer.

Ownership is carried by one bit in the config word. A descriptor with the bit clear belongs to the engine. A descriptor with the bit set is empty, and finding one makes the engine stop. Stopping drops the enable bit, so software sees the halt by polling the control register until it reads zero. Because the chain is followed by pointer, a ring whose last entry points back at the first is walked circularly. A status register counts finished packets.

Top module: `ring_tx_dma`

## Requirements
- R1: After reset the control (offset 0x180), pointer (0x184) and status (0x188) registers read 0, tx_valid is low and no memory request is made.
- R2: Writing a value with bit 0 set to the control register while it reads 0 makes it read 1 and starts processing at the descriptor whose address is in the pointer register.
- R3: A descriptor at address P holds the buffer address at P, the config word at P+4 and the next-descriptor address at P+8. In the config word, bit 31 is the empty flag and bits 11:0 are the byte length. Buffer addresses are word aligned.
- R4: For a descriptor with the empty flag clear and a nonzero length L, exactly L bytes are sent from the buffer in ascending address order. Byte 0 of each word comes from bits 7:0. tx_last is high on the final byte only.
- R5: While tx_valid is high and tx_ready is low, tx_data and tx_last hold their values.
- R6: When a descriptor is finished, its config word is written back to P+4 with bit 31 set and every other bit unchanged.
- R7: After the write-back the pointer register takes the next-descriptor address, so a ring that wraps from its last entry to its first is followed across the wrap.
- R8: When the fetched config word has bit 31 set, no byte is sent, nothing is written, the pointer register keeps that descriptor's address and the control register drops to 0.
- R9: A descriptor with the empty flag clear and length 0 sends no byte but is still written back, advanced past and counted.
- R10: Status bits 7:0 count finished descriptors and wrap modulo 256. Writing the status register clears exactly the count bits written as 1.
- R11: Writing 0 to the control register while it reads 1 lets the descriptor in progress finish. The engine then stops with the control register at 0 and the pointer on the following descriptor.
- R12: A write to the pointer register while the control register reads 1 has no effect.
- R13: A memory request keeps its address, direction and write data unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 12 | Register byte offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data, combinational from csr_addr |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address of the request |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle acknowledge, completes the request |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| tx_valid | output | 1 | Byte available |
| tx_data | output | 8 | Packet byte |
| tx_last | output | 1 | Final byte of the packet |
| tx_ready | input | 1 | Sink accepts the byte |

## Verification
The bench builds rings that mix lengths of 1, 4, 5, 0 and random values, and it throttles both tx_ready and the memory acknowledge at random. A word-splitting bug would show up as dropped or repeated bytes at length boundaries that fall on a word edge. A missing zero-length path would either hang or emit a stray byte. The walk is also run starting on an empty entry, and across the ring wrap. Wrong ownership handling would either advance the pointer past the empty descriptor or fail to follow the wrap. A stop request is issued in the middle of a long packet. An engine that stopped early would cut the packet short, and one that ignored the request would go on into the next descriptor.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
    localparam logic [11:0] OFS_CTRL = 12'h180;
    localparam logic [11:0] OFS_PTR  = 12'h184;
    localparam logic [11:0] OFS_STAT = 12'h188;

    localparam int unsigned EMPTY_BIT = 31;
    localparam int unsigned LEN_W     = 12;
    localparam int unsigned WORD_W    = 32;

    typedef enum logic [2:0] {
        W_IDLE,
        W_CFG,
        W_BUF,
        W_NXT,
        W_LOAD,
        W_SEND,
        W_WB
    } walk_e;
endpackage

// File: rtl/rdma_csr.sv
module rdma_csr
    import rdma_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [11:0]       addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    input  logic              halt_i,
    input  logic              adv_i,
    input  logic [AW-1:0]     next_i,
    input  logic              done_i,
    output logic              en_o,
    output logic              stop_o,
    output logic [AW-1:0]     ptr_o
);
    typedef struct packed {
        logic             en;
        logic             stop;
        logic [AW-1:0]    ptr;
        logic [CNT_W-1:0] cnt;
    } csr_t;

    csr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we_i) begin
            unique case (addr_i)
                OFS_CTRL: begin
                    if (!s_q.en && wdata_i[0])      s_d.en   = 1'b1;
                    else if (s_q.en && !wdata_i[0]) s_d.stop = 1'b1;
                end
                OFS_PTR: begin
                    if (!s_q.en) s_d.ptr = wdata_i[AW-1:0];
                end
                OFS_STAT: s_d.cnt = s_q.cnt & ~wdata_i[CNT_W-1:0];
                default: ;
            endcase
        end
        if (adv_i)  s_d.ptr = next_i;
        if (done_i) s_d.cnt = s_d.cnt + CNT_W'(1);
        if (halt_i) begin
            s_d.en   = 1'b0;
            s_d.stop = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            OFS_CTRL: rdata_o = {31'd0, s_q.en};
            OFS_PTR:  rdata_o = 32'(s_q.ptr);
            OFS_STAT: rdata_o = 32'(s_q.cnt);
            default:  rdata_o = '0;
        endcase
    end

    assign en_o   = s_q.en;
    assign stop_o = s_q.stop;
    assign ptr_o  = s_q.ptr;

    // R8
    halt_drops_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_i |=> !s_q.en);

    // R12
    ptr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.en && !adv_i) |=> $stable(s_q.ptr));

    // R10
    cnt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_i && !(we_i && addr_i == OFS_STAT)) |=> $stable(s_q.cnt));
endmodule

// File: rtl/rdma_ser.sv
module rdma_ser #(
    parameter int unsigned W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic [W-1:0]   word_i,
    input  logic [$clog2(W/8+1)-1:0] nbytes_i,
    input  logic           final_i,
    input  logic           tx_ready_i,
    output logic           tx_valid_o,
    output logic [7:0]     tx_data_o,
    output logic           tx_last_o,
    output logic           busy_o
);
    localparam int unsigned CW = $clog2(W/8+1);

    typedef struct packed {
        logic [W-1:0]  word;
        logic [CW-1:0] cnt;
        logic          fin;
    } ser_t;

    ser_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.word = word_i;
            s_d.cnt  = nbytes_i;
            s_d.fin  = final_i;
        end else if (s_q.cnt != '0 && tx_ready_i) begin
            s_d.word = s_q.word >> 8;
            s_d.cnt  = s_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tx_valid_o = (s_q.cnt != '0);
    assign tx_data_o  = s_q.word[7:0];
    assign tx_last_o  = s_q.fin && (s_q.cnt == CW'(1));
    assign busy_o     = tx_valid_o;

    // R5
    hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o)));

    // R4
    no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !busy_o);
endmodule

// File: rtl/rdma_walk.sv
module rdma_walk
    import rdma_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              stop_i,
    input  logic [AW-1:0]     ptr_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [31:0]       mem_rdata_i,
    input  logic              ser_busy_i,
    output logic              ser_load_o,
    output logic [DW-1:0]     ser_word_o,
    output logic [$clog2(DW/8+1)-1:0] ser_nbytes_o,
    output logic              ser_final_o,
    output logic              halt_o,
    output logic              adv_o,
    output logic [AW-1:0]     next_o,
    output logic              done_o
);
    localparam int unsigned NB  = DW / 8;
    localparam int unsigned NBW = $clog2(NB + 1);

    typedef struct packed {
        walk_e            st;
        logic [31:0]      cfg;
        logic [AW-1:0]    bufa;
        logic [AW-1:0]    nxt;
        logic [AW-1:0]    off;
        logic [LEN_W-1:0] rem;
    } walk_t;

    walk_t s_d, s_q;
    logic [LEN_W-1:0] take;

    always_comb begin
        take = (s_q.rem > LEN_W'(NB)) ? LEN_W'(NB) : s_q.rem;
    end

    always_comb begin
        s_d          = s_q;
        mem_req_o    = 1'b0;
        mem_we_o     = 1'b0;
        mem_addr_o   = '0;
        mem_wdata_o  = '0;
        ser_load_o   = 1'b0;
        ser_word_o   = DW'(mem_rdata_i);
        ser_nbytes_o = NBW'(take);
        ser_final_o  = (s_q.rem <= LEN_W'(NB));
        halt_o       = 1'b0;
        adv_o        = 1'b0;
        done_o       = 1'b0;
        unique case (s_q.st)
            W_IDLE: begin
                if (en_i) s_d.st = W_CFG;
            end
            W_CFG: begin
                mem_req_o  = 1'b1;
                mem_addr_o = ptr_i + AW'(4);
                if (mem_ack_i) begin
                    if (mem_rdata_i[EMPTY_BIT]) begin
                        halt_o = 1'b1;
                        s_d.st = W_IDLE;
                    end else begin
                        s_d.cfg = mem_rdata_i;
                        s_d.rem = mem_rdata_i[LEN_W-1:0];
                        s_d.st  = W_BUF;
                    end
                end
            end
            W_BUF: begin
                mem_req_o  = 1'b1;
                mem_addr_o = ptr_i;
                if (mem_ack_i) begin
                    s_d.bufa = mem_rdata_i[AW-1:0];
                    s_d.st   = W_NXT;
                end
            end
            W_NXT: begin
                mem_req_o  = 1'b1;
                mem_addr_o = ptr_i + AW'(8);
                if (mem_ack_i) begin
                    s_d.nxt = mem_rdata_i[AW-1:0];
                    s_d.off = '0;
                    s_d.st  = (s_q.rem == '0) ? W_WB : W_LOAD;
                end
            end
            W_LOAD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = s_q.bufa + s_q.off;
                if (mem_ack_i) begin
                    ser_load_o = 1'b1;
                    s_d.rem    = s_q.rem - take;
                    s_d.off    = s_q.off + AW'(NB);
                    s_d.st     = W_SEND;
                end
            end
            W_SEND: begin
                if (!ser_busy_i) s_d.st = (s_q.rem == '0) ? W_WB : W_LOAD;
            end
            W_WB: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = ptr_i + AW'(4);
                mem_wdata_o = s_q.cfg | (32'd1 << EMPTY_BIT);
                if (mem_ack_i) begin
                    adv_o  = 1'b1;
                    done_o = 1'b1;
                    if (stop_i) begin
                        halt_o = 1'b1;
                        s_d.st = W_IDLE;
                    end else begin
                        s_d.st = W_CFG;
                    end
                end
            end
            default: s_d.st = W_IDLE;
        endcase
    end

    assign next_o = s_q.nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: W_IDLE, default: '0};
        else        s_q <= s_d;
    end

    // R13
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)
                                       && $stable(mem_we_o) && $stable(mem_wdata_o)));

    // R6
    wb_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o) |-> mem_wdata_o[EMPTY_BIT]);

    // R2
    busy_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != W_IDLE) |-> en_i);
endmodule

// File: rtl/ring_tx_dma.sv
module ring_tx_dma
    import rdma_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned CNT_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          csr_we,
    input  logic [11:0]   csr_addr,
    input  logic [31:0]   csr_wdata,
    output logic [31:0]   csr_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    input  logic          tx_ready
);
    localparam int unsigned NBW = $clog2(WORD_W/8 + 1);

    logic              en, stop, halt, adv, done;
    logic [AW-1:0]     ptr, nxt;
    logic              ser_busy, ser_load, ser_final;
    logic [WORD_W-1:0] ser_word;
    logic [NBW-1:0]    ser_nbytes;

    rdma_csr #(.AW(AW), .CNT_W(CNT_W)) u_csr (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (csr_we),
        .addr_i  (csr_addr),
        .wdata_i (csr_wdata),
        .rdata_o (csr_rdata),
        .halt_i  (halt),
        .adv_i   (adv),
        .next_i  (nxt),
        .done_i  (done),
        .en_o    (en),
        .stop_o  (stop),
        .ptr_o   (ptr)
    );

    rdma_walk #(.AW(AW), .DW(WORD_W)) u_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en),
        .stop_i       (stop),
        .ptr_i        (ptr),
        .mem_req_o    (mem_req),
        .mem_we_o     (mem_we),
        .mem_addr_o   (mem_addr),
        .mem_wdata_o  (mem_wdata),
        .mem_ack_i    (mem_ack),
        .mem_rdata_i  (mem_rdata),
        .ser_busy_i   (ser_busy),
        .ser_load_o   (ser_load),
        .ser_word_o   (ser_word),
        .ser_nbytes_o (ser_nbytes),
        .ser_final_o  (ser_final),
        .halt_o       (halt),
        .adv_o        (adv),
        .next_o       (nxt),
        .done_o       (done)
    );

    rdma_ser #(.W(WORD_W)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ser_load),
        .word_i     (ser_word),
        .nbytes_i   (ser_nbytes),
        .final_i    (ser_final),
        .tx_ready_i (tx_ready),
        .tx_valid_o (tx_valid),
        .tx_data_o  (tx_data),
        .tx_last_o  (tx_last),
        .busy_o     (ser_busy)
    );
endmodule

// File: tb/ring_tx_dma_test.sv
module ring_tx_dma_test;
    localparam int CLK_P = 10;
    localparam logic [31:0] RING = 32'h100;
    localparam logic [31:0] BUFS = 32'h1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        tx_valid, tx_last;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;

    logic [31:0] mem [0:4095];
    logic [1:0]  lat = '0;
    int          checks = 0, fails = 0;
    bit          finished = 0;
    logic [7:0]  got_q[$], exp_q[$];
    bit          gotl_q[$], expl_q[$];
    logic [31:0] cfg_orig [0:7];

    always #(CLK_P/2) clk = ~clk;

    ring_tx_dma uut (.*);

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            lat     <= '0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (lat == 0) begin
                mem_ack   <= 1'b1;
                mem_rdata <= mem[mem_addr[13:2]];
                if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
                lat <= 2'($urandom_range(2, 0));
            end else begin
                lat <= lat - 2'd1;
            end
        end
    end

    always @(negedge clk) tx_ready <= ($urandom_range(3, 0) != 0);

    always @(posedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            got_q.push_back(tx_data);
            gotl_q.push_back(tx_last);
        end
    end

    function automatic logic [31:0] daddr(int i);
        return RING + 32'(12 * i);
    endfunction

    function automatic logic [7:0] byte_at(logic [31:0] a);
        logic [31:0] w = mem[a[13:2]];
        return w[8*a[1:0] +: 8];
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        csr_addr = a;
        #1 d = csr_rdata;
    endtask

    // fills descriptor i; a full one also queues its expected bytes
    task automatic put_desc(int i, int len, bit empty);
        logic [31:0] b = BUFS + 32'(i * 256);
        logic [31:0] c = 32'(len) | (32'(i + 1) << 16) | (empty ? 32'h8000_0000 : 32'h0);
        mem[daddr(i)[13:2]]     = b;
        mem[daddr(i)[13:2] + 1] = c;
        mem[daddr(i)[13:2] + 2] = daddr((i + 1) % 8);
        cfg_orig[i] = c;
        if (!empty) begin
            for (int k = 0; k < len; k++) begin
                exp_q.push_back(byte_at(b + 32'(k)));
                expl_q.push_back(k == len - 1);
            end
        end
    endtask

    task automatic wait_halt(string req);
        logic [31:0] d;
        int n = 0;
        do begin
            rd(12'h180, d);
            n++;
        end while (d[0] && n < 20000);
        repeat (4) @(negedge clk);
        chk(d == 0, req, d, 0);
    endtask

    task automatic cmp_stream(string req);
        int bad = 0, badl = 0;
        chk(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
        if (got_q.size() == exp_q.size()) begin
            for (int k = 0; k < exp_q.size(); k++) begin
                if (got_q[k] !== exp_q[k]) bad++;
                if (gotl_q[k] !== expl_q[k]) badl++;
            end
        end
        chk(bad == 0, {req, " bytes"}, bad, 0);
        chk(badl == 0, {req, " R4 last flag"}, badl, 0);
        got_q.delete(); exp_q.delete(); gotl_q.delete(); expl_q.delete();
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired (all requirements)");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(1234));
        for (int k = 0; k < 4096; k++) mem[k] = $urandom();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(12'h180, d); chk(d == 0, "R1 ctrl", d, 0);
        rd(12'h184, d); chk(d == 0, "R1 ptr", d, 0);
        rd(12'h188, d); chk(d == 0, "R1 status", d, 0);
        chk(!tx_valid && !mem_req, "R1 idle outputs", {tx_valid, mem_req}, 0);

        // R3 R4 R9: lengths random, 1, 0, 5, 4 then an empty entry
        put_desc(0, $urandom_range(256, 1), 0);
        put_desc(1, 1, 0);
        put_desc(2, 0, 0);
        put_desc(3, 5, 0);
        put_desc(4, 4, 0);
        put_desc(5, 0, 1);
        put_desc(6, 0, 1);
        put_desc(7, 0, 1);
        wr(12'h184, RING);
        wr(12'h180, 32'h1);
        rd(12'h180, d); chk(d == 1, "R2 enable reads 1", d, 1);
        wr(12'h184, 32'h300);   // R12 ignored while running
        wait_halt("R8 halt on empty");
        cmp_stream("R4 R5 R13 stream");
        rd(12'h184, d); chk(d == daddr(5), "R7 R12 ptr", d, daddr(5));
        rd(12'h188, d); chk(d == 5, "R9 R10 count", d, 5);
        for (int i = 0; i < 5; i++)
            chk(mem[daddr(i)[13:2] + 1] == (cfg_orig[i] | 32'h8000_0000), "R6 writeback",
                mem[daddr(i)[13:2] + 1], cfg_orig[i] | 32'h8000_0000);

        // R10 write-one-to-clear
        wr(12'h188, 32'h1);
        rd(12'h188, d); chk(d == 4, "R10 clear bit0", d, 4);
        wr(12'h188, 32'hFF);
        rd(12'h188, d); chk(d == 0, "R10 clear all", d, 0);

        // R8 start on an empty entry
        wr(12'h180, 32'h1);
        wait_halt("R8 immediate halt");
        cmp_stream("R8 no bytes");
        rd(12'h184, d); chk(d == daddr(5), "R8 ptr kept", d, daddr(5));
        rd(12'h188, d); chk(d == 0, "R8 no count", d, 0);

        // R7 wrap: 5,6,7,0 full, 1 already empty
        put_desc(5, $urandom_range(256, 1), 0);
        put_desc(6, $urandom_range(256, 1), 0);
        put_desc(7, $urandom_range(256, 1), 0);
        put_desc(0, $urandom_range(256, 1), 0);
        wr(12'h180, 32'h1);
        wait_halt("R7 wrap halt");
        cmp_stream("R7 wrap stream");
        rd(12'h184, d); chk(d == daddr(1), "R7 wrap ptr", d, daddr(1));
        rd(12'h188, d); chk(d == 4, "R7 wrap count", d, 4);
        wr(12'h188, 32'hFF);

        // R11 stop mid-packet
        put_desc(1, 200, 0);
        put_desc(2, 17, 0);
        put_desc(3, 9, 0);
        exp_q = exp_q[0:199];
        expl_q = expl_q[0:199];
        wr(12'h180, 32'h1);
        wr(12'h180, 32'h0);
        rd(12'h180, d); chk(d == 1, "R11 still running", d, 1);
        wait_halt("R11 stop");
        cmp_stream("R11 stream");
        rd(12'h184, d); chk(d == daddr(2), "R11 ptr", d, daddr(2));
        rd(12'h188, d); chk(d == 1, "R11 count", d, 1);
        chk(mem[daddr(2)[13:2] + 1] == cfg_orig[2], "R11 next untouched",
            mem[daddr(2)[13:2] + 1], cfg_orig[2]);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule